// File: doc/BRIEF.md
# Return-From-Trap Control Unit

This block resolves a return-from-trap instruction. The pipeline pulses a one-cycle request together with the current program counter, the processor status bits (supervisor, previous supervisor, trap enable), the core's debug-mode flag, the instruction's one-bit debug-return field and the saved return state. One clock later the block presents the resolved next program counter, the status bits to write back with a write strobe, a strobe that clears debug mode, and halt or illegal-instruction requests.

There are two return paths. The normal path applies when the core is outside debug mode and the debug field is 0. The debug path applies when the core is in debug mode and the field is 1. The path is chosen only after two checks, in fixed priority order. The first check is whether the core is in supervisor state. The second is whether traps are still enabled. A request whose combination matches no path just steps the program counter by one word. Every request is accepted, so the block applies no back-pressure. The result is a single-cycle pulse that is marked valid and has no ready.

Top module: `trap_return_unit`

## Requirements
- R1: While reset (active low, synchronous) is asserted and on the first cycle after it, `res_valid`, `halt_req`, `illegal_req`, `stat_we` and `dbg_clr` are 0 and `next_pc` is 0.
- R2: `res_valid` is 1 exactly in the cycle after a cycle with `req` high, and 0 otherwise.
- R3: With supervisor 0 and trap enable 0, the result has `halt_req`=1, `next_pc`=`cur_pc`+4, and `stat_we`, `dbg_clr` and `illegal_req` all 0.
- R4: With supervisor 0 and trap enable 1, the result has `next_pc`=`cur_pc`+4 and all of `halt_req`, `illegal_req`, `stat_we` and `dbg_clr` at 0. The privilege fault is raised outside this block.
- R5: With supervisor 1 and trap enable 1, the result has `illegal_req`=1, `next_pc`=`cur_pc`+4, and no status write, halt or debug clear. This holds whatever the debug mode and debug field are.
- R6: With supervisor 1, trap enable 0, debug mode 0 and field 0, the result has `next_pc`=`trap_pc` and `stat_we`=1. It sets `new_et`=1 and `new_sup`=`prev_sup`, and `dbg_clr`=0.
- R7: With supervisor 1, trap enable 0, debug mode 1 and field 1, the result has `next_pc`=`dbg_pc`, `stat_we`=1, `new_et`=`dbg_et`, `new_sup`=`dbg_sup` and `dbg_clr`=1.
- R8: With supervisor 1 and trap enable 0, a debug mode that differs from the field gives `next_pc`=`cur_pc`+4 and no strobe at all.
- R9: At most one of `halt_req`, `illegal_req` and `stat_we` is 1 in any cycle. None of them, and not `dbg_clr`, is 1 unless `res_valid` is 1.
- R10: The step of `cur_pc`+4 wraps modulo 2^32, so 0xFFFFFFFC gives 0.
- R11: `next_pc`, `new_sup` and `new_et` keep their values in any cycle that follows a cycle without `req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req | input | 1 | One-cycle request for a return-from-trap |
| cur_pc | input | 32 | PC of the return instruction, word aligned |
| sup | input | 1 | Current supervisor bit |
| prev_sup | input | 1 | Previous supervisor bit |
| trap_en | input | 1 | Current trap-enable bit |
| dbg_mode | input | 1 | Core is in debug mode |
| dbg_field | input | 1 | Instruction selects the debug return |
| trap_pc | input | 32 | Saved PC for a normal return |
| dbg_pc | input | 32 | Saved PC for a debug return |
| dbg_et | input | 1 | Saved trap-enable bit for a debug return |
| dbg_sup | input | 1 | Saved supervisor bit for a debug return |
| res_valid | output | 1 | Result outputs below are valid this cycle |
| next_pc | output | 32 | Resolved next PC |
| new_sup | output | 1 | Supervisor bit to write |
| new_et | output | 1 | Trap-enable bit to write |
| stat_we | output | 1 | Write strobe for new_sup/new_et |
| dbg_clr | output | 1 | Clear the debug-mode flag |
| halt_req | output | 1 | Halt request |
| illegal_req | output | 1 | Illegal-instruction request |

## Verification
The assertions assume that `req` is never held high on two consecutive cycles, because the pipeline issues one instruction per strobe. They also assume that the PC inputs are word aligned. The stimulus pulses `req` for one cycle and then leaves at least one idle cycle before the next request. It draws PCs with their two low bits forced to zero. During the idle cycles it scrambles the other inputs, so that the hold requirement is exercised against changing inputs.

// File: rtl/trap_return_pkg.sv
package trap_return_pkg;
  typedef enum logic [2:0] {
    RP_HALT    = 3'd0,
    RP_PRIV    = 3'd1,
    RP_ILLEGAL = 3'd2,
    RP_NORMAL  = 3'd3,
    RP_DEBUG   = 3'd4,
    RP_SKIP    = 3'd5
  } ret_path_t;

  typedef struct packed {
    logic sup;
    logic et;
    logic we;
    logic clr;
    logic halt;
    logic illegal;
  } ret_ctl_t;
endpackage

// File: rtl/trap_return_classify.sv
module trap_return_classify
  import trap_return_pkg::*;
(
  input  logic      sup,
  input  logic      trap_en,
  input  logic      dbg_mode,
  input  logic      dbg_field,
  output ret_path_t path
);
  // Ordered checks: privilege, then enabled traps, then the two returns.
  always_comb begin
    if (!sup)
      path = trap_en ? RP_PRIV : RP_HALT;
    else if (trap_en)
      path = RP_ILLEGAL;
    else if (!dbg_mode && !dbg_field)
      path = RP_NORMAL;
    else if (dbg_mode && dbg_field)
      path = RP_DEBUG;
    else
      path = RP_SKIP;
  end
endmodule

// File: rtl/trap_return_select.sv
module trap_return_select
  import trap_return_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int STEP = 4
) (
  input  ret_path_t       path,
  input  logic [PC_W-1:0] cur_pc,
  input  logic [PC_W-1:0] trap_pc,
  input  logic [PC_W-1:0] dbg_pc,
  input  logic            prev_sup,
  input  logic            dbg_et,
  input  logic            dbg_sup,
  output logic [PC_W-1:0] pc_out,
  output ret_ctl_t        ctl
);
  localparam logic [PC_W-1:0] STEP_V = PC_W'(STEP);

  logic [PC_W-1:0] seq_pc;
  assign seq_pc = cur_pc + STEP_V;

  always_comb begin
    pc_out = seq_pc;
    ctl    = '0;
    unique case (path)
      RP_HALT:    ctl.halt = 1'b1;
      RP_PRIV:    ;
      RP_ILLEGAL: ctl.illegal = 1'b1;
      RP_NORMAL: begin
        pc_out  = trap_pc;
        ctl.we  = 1'b1;
        ctl.et  = 1'b1;
        ctl.sup = prev_sup;
      end
      RP_DEBUG: begin
        pc_out  = dbg_pc;
        ctl.we  = 1'b1;
        ctl.clr = 1'b1;
        ctl.et  = dbg_et;
        ctl.sup = dbg_sup;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/trap_return_unit.sv
module trap_return_unit
  import trap_return_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [PC_W-1:0] cur_pc,
  input  logic            sup,
  input  logic            prev_sup,
  input  logic            trap_en,
  input  logic            dbg_mode,
  input  logic            dbg_field,
  input  logic [PC_W-1:0] trap_pc,
  input  logic [PC_W-1:0] dbg_pc,
  input  logic            dbg_et,
  input  logic            dbg_sup,
  output logic            res_valid,
  output logic [PC_W-1:0] next_pc,
  output logic            new_sup,
  output logic            new_et,
  output logic            stat_we,
  output logic            dbg_clr,
  output logic            halt_req,
  output logic            illegal_req
);
  ret_path_t       path;
  logic [PC_W-1:0] pc_d;
  ret_ctl_t        ctl_d;

  trap_return_classify u_classify (
    .sup       (sup),
    .trap_en   (trap_en),
    .dbg_mode  (dbg_mode),
    .dbg_field (dbg_field),
    .path      (path)
  );

  trap_return_select #(.PC_W(PC_W), .STEP(STEP)) u_select (
    .path     (path),
    .cur_pc   (cur_pc),
    .trap_pc  (trap_pc),
    .dbg_pc   (dbg_pc),
    .prev_sup (prev_sup),
    .dbg_et   (dbg_et),
    .dbg_sup  (dbg_sup),
    .pc_out   (pc_d),
    .ctl      (ctl_d)
  );

  // Strobes are single-cycle pulses; data outputs hold between requests.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      next_pc     <= '0;
      new_sup     <= 1'b0;
      new_et      <= 1'b0;
      stat_we     <= 1'b0;
      dbg_clr     <= 1'b0;
      halt_req    <= 1'b0;
      illegal_req <= 1'b0;
    end else begin
      res_valid   <= req;
      stat_we     <= req & ctl_d.we;
      dbg_clr     <= req & ctl_d.clr;
      halt_req    <= req & ctl_d.halt;
      illegal_req <= req & ctl_d.illegal;
      if (req) begin
        next_pc <= pc_d;
        new_sup <= ctl_d.sup;
        new_et  <= ctl_d.et;
      end
    end
  end

  p_valid_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> res_valid);
  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !res_valid);
  p_halt_path_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !sup && !trap_en) |=> (halt_req && !stat_we && next_pc == $past(cur_pc) + PC_W'(STEP)));
  p_priv_path_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !sup && trap_en) |=> (!halt_req && !illegal_req && !stat_we && !dbg_clr));
  p_illegal_path_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && sup && trap_en) |=> (illegal_req && !stat_we && !dbg_clr));
  p_normal_ret_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req && sup && !trap_en && !dbg_mode && !dbg_field) |=>
      (stat_we && new_et && next_pc == $past(trap_pc) && new_sup == $past(prev_sup)));
  p_debug_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && sup && !trap_en && dbg_mode && dbg_field) |=>
      (dbg_clr && stat_we && next_pc == $past(dbg_pc)));
  p_clr_needs_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_clr |-> stat_we);
  p_one_action_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_req, illegal_req, stat_we}));
  p_strobe_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req || illegal_req || stat_we || dbg_clr) |-> res_valid);
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> ($stable(next_pc) && $stable(new_sup) && $stable(new_et)));
endmodule

// File: tb/test_trap_return_unit.sv
module test_trap_return_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req;
  logic [31:0] cur_pc, trap_pc, dbg_pc;
  logic        sup, prev_sup, trap_en, dbg_mode, dbg_field, dbg_et, dbg_sup;
  logic        res_valid, new_sup, new_et, stat_we, dbg_clr, halt_req, illegal_req;
  logic [31:0] next_pc;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  trap_return_unit i_trap_return_unit (
    .clk(clk), .rst_n(rst_n), .req(req), .cur_pc(cur_pc), .sup(sup),
    .prev_sup(prev_sup), .trap_en(trap_en), .dbg_mode(dbg_mode),
    .dbg_field(dbg_field), .trap_pc(trap_pc), .dbg_pc(dbg_pc),
    .dbg_et(dbg_et), .dbg_sup(dbg_sup), .res_valid(res_valid),
    .next_pc(next_pc), .new_sup(new_sup), .new_et(new_et),
    .stat_we(stat_we), .dbg_clr(dbg_clr), .halt_req(halt_req),
    .illegal_req(illegal_req)
  );

  // Packed expected result: {valid, pc, sup, et, we, clr, halt, illegal}
  function automatic logic [38:0] model(input logic s, et, m, f, ps, bet, bs,
                                        input logic [31:0] pc, tpc, bpc);
    logic [31:0] np;
    logic ns, ne, we, cl, h, il;
    np = pc + 32'd4; ns = 0; ne = 0; we = 0; cl = 0; h = 0; il = 0;
    if (!s) h = !et;
    else if (et) il = 1;
    else if (!m && !f) begin np = tpc; we = 1; ne = 1; ns = ps; end
    else if (m && f) begin np = bpc; we = 1; cl = 1; ne = bet; ns = bs; end
    return {1'b1, np, ns, ne, we, cl, h, il};
  endfunction

  function automatic string tag(input logic s, et, m, f);
    if (!s) return et ? "R4" : "R3";
    if (et) return "R5";
    if (!m && !f) return "R6";
    if (m && f) return "R7";
    return "R8";
  endfunction

  logic [38:0] last_exp;

  task automatic check(input string rq, input logic [38:0] exp);
    logic [38:0] act;
    act = {res_valid, next_pc, new_sup, new_et, stat_we, dbg_clr, halt_req, illegal_req};
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  task automatic apply(input logic s, et, m, f, ps, bet, bs,
                       input logic [31:0] pc, tpc, bpc);
    logic [38:0] e;
    sup = s; trap_en = et; dbg_mode = m; dbg_field = f; prev_sup = ps;
    dbg_et = bet; dbg_sup = bs; cur_pc = pc; trap_pc = tpc; dbg_pc = bpc;
    req = 1'b1;
    e = model(s, et, m, f, ps, bet, bs, pc, tpc, bpc);
    @(negedge clk);
    req = 1'b0;
    check(tag(s, et, m, f), e);
    // R2: result is a single pulse; data held (R11) while inputs scramble
    sup = 1'($urandom); trap_en = 1'($urandom); cur_pc = $urandom & 32'hFFFF_FFFC;
    trap_pc = $urandom & 32'hFFFF_FFFC; prev_sup = 1'($urandom);
    @(negedge clk);
    last_exp = {1'b0, e[37:36], e[35:34], 4'b0};
    last_exp = {1'b0, e[37:4], 4'b0};
    check("R11", last_exp);
  endtask

  initial begin
    process::self().srandom(32'd1234);
    rst_n = 0; req = 0; cur_pc = 32'h1234_5678; trap_pc = 0; dbg_pc = 0;
    sup = 1; prev_sup = 1; trap_en = 0; dbg_mode = 0; dbg_field = 0;
    dbg_et = 0; dbg_sup = 0;
    @(negedge clk);
    check("R1", 39'd0);
    req = 1;
    @(negedge clk);
    check("R1", 39'd0);
    rst_n = 1; req = 0;
    @(negedge clk);
    check("R1", 39'd0);

    apply(0, 0, 0, 0, 1, 1, 1, 32'h0000_1000, 32'h2000, 32'h3000); // R3
    apply(0, 1, 1, 1, 1, 1, 1, 32'h0000_1004, 32'h2000, 32'h3000); // R4
    apply(1, 1, 0, 0, 1, 1, 1, 32'h0000_1008, 32'h2000, 32'h3000); // R5
    apply(1, 1, 1, 1, 0, 0, 0, 32'h0000_100C, 32'h2000, 32'h3000); // R5
    apply(1, 0, 0, 0, 0, 1, 1, 32'h0000_1010, 32'h8000_0040, 32'h3000); // R6
    apply(1, 0, 0, 0, 1, 0, 0, 32'h0000_1010, 32'h8000_0080, 32'h3000); // R6
    apply(1, 0, 1, 1, 1, 0, 1, 32'h0000_1014, 32'h2000, 32'hC000_0100); // R7
    apply(1, 0, 1, 1, 0, 1, 0, 32'h0000_1014, 32'h2000, 32'hC000_0200); // R7
    apply(1, 0, 1, 0, 1, 1, 1, 32'h0000_1018, 32'h2000, 32'h3000); // R8
    apply(1, 0, 0, 1, 1, 1, 1, 32'h0000_101C, 32'h2000, 32'h3000); // R8
    apply(0, 0, 0, 0, 0, 0, 0, 32'hFFFF_FFFC, 32'h2000, 32'h3000); // R10
    apply(1, 0, 1, 0, 0, 0, 0, 32'hFFFF_FFFC, 32'h2000, 32'h3000); // R10

    for (int i = 0; i < 400; i++) begin
      apply(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom),
            $urandom & 32'hFFFF_FFFC, $urandom & 32'hFFFF_FFFC,
            $urandom & 32'hFFFF_FFFC);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule